// File: doc/BRIEF.md
# Automatic Transmit/Receive GPIO Switcher

This block drives four 16-bit peripheral output banks, one for each of four slots (transmit A = 0, receive A = 1, transmit B = 2, receive B = 3). Every bank has a plain software output register and three switching registers: a per-pin mask, a transmit pattern and a receive pattern. All of them are loaded through a simple single-cycle register-write port.

A status input reports on every cycle whether the transmit FIFO holds data. The block captures that flag once. It then uses the registered flag to choose, for every masked pin, either the transmit pattern (FIFO holds data) or the receive pattern (FIFO empty). Pins whose mask bit is clear keep following the software output register. External radio switches and amplifier enables therefore track traffic without software involvement, while the remaining pins stay under software control.

Top module: `atr_gpio_switcher`

## Requirements
- R1: While reset is low and on the first cycle after release, every mask, pattern and output register reads zero, so `pin_out` is all zeros.
- R2: With default parameters, slot s (0..3) has its mask at address 20+3s, its transmit pattern at 21+3s, its receive pattern at 22+3s and its software output register at 8+s.
- R3: A write accepted on a rising edge appears on `pin_out` right after that edge and not before it.
- R4: A pin whose mask bit is 0 outputs the matching bit of its bank's software output register, whatever the status flag is.
- R5: A pin whose mask bit is 1 outputs the matching transmit-pattern bit while the registered status flag is 1.
- R6: A pin whose mask bit is 1 outputs the matching receive-pattern bit while the registered status flag is 0.
- R7: `txq_nonempty` passes through exactly one register, so every pin of every bank switches on the same edge, one edge after the flag is sampled.
- R8: A write to an address outside the map (for example 0, 12, 19 or 40) changes no register and no pin.
- R9: A write to one bank's register leaves the pins of the other three banks unchanged.
- R10: When `wr_en` is low, `wr_addr` and `wr_data` have no effect.
- R11: Bank s occupies bits 16s+15 down to 16s of `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 7 | Register address |
| wr_data | input | 16 | Register write data |
| txq_nonempty | input | 1 | High while the transmit FIFO holds data |
| pin_out | output | 64 | Merged pin values, bank s in bits 16s+15:16s |

## Verification
Register writes and status changes each have a latency of one edge. A write or a new flag value is driven at a falling edge, captured at the next rising edge, and due on `pin_out` at the falling edge after that. The bench therefore drives at falling edges and samples at falling edges. For R3 and R7 it also samples half a cycle early, just after driving, to confirm that the old value still holds before the capturing edge.

// File: rtl/atr_gpio_pkg.sv
// Package: shared register-kind encoding for the switcher.
// Assumes: a register address selects at most one kind for one bank.
package atr_gpio_pkg;

    // Kind of register a write targets.
    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_MASK = 3'd1,
        KIND_TXV  = 3'd2,
        KIND_RXV  = 3'd3,
        KIND_IO   = 3'd4
    } reg_kind_e;

    // Offset of a switching register inside one slot's group of three.
    function automatic int unsigned kind_offset(reg_kind_e k);
        case (k)
            KIND_MASK: return 0;
            KIND_TXV:  return 1;
            KIND_RXV:  return 2;
            default:   return 0;
        endcase
    endfunction

    // Stride between successive slots in the switching register block.
    localparam int unsigned SLOT_STRIDE = 3;

endpackage

// File: rtl/atr_reg_decode.sv
// Module: atr_reg_decode
// Turns one write request into per-bank, per-kind write strobes.
// Assumes: ATR_BASE..ATR_BASE+3*NUM_BANKS-1 and IO_BASE..IO_BASE+NUM_BANKS-1
// do not overlap; unmapped addresses raise no strobe.
module atr_reg_decode
    import atr_gpio_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 7,
    parameter int ATR_BASE  = 20,
    parameter int IO_BASE   = 8
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [NUM_BANKS-1:0] we_mask,
    output logic [NUM_BANKS-1:0] we_txv,
    output logic [NUM_BANKS-1:0] we_rxv,
    output logic [NUM_BANKS-1:0] we_io
);

    genvar s;
    generate
        for (s = 0; s < NUM_BANKS; s++) begin : g_slot
            localparam int MASK_A = ATR_BASE + SLOT_STRIDE * s + kind_offset(KIND_MASK);
            localparam int TXV_A  = ATR_BASE + SLOT_STRIDE * s + kind_offset(KIND_TXV);
            localparam int RXV_A  = ATR_BASE + SLOT_STRIDE * s + kind_offset(KIND_RXV);
            localparam int IO_A   = IO_BASE + s;

            // Compare the address against this slot's four registers.
            always_comb begin
                we_mask[s] = wr_en && (wr_addr == ADDR_W'(MASK_A));
                we_txv[s]  = wr_en && (wr_addr == ADDR_W'(TXV_A));
                we_rxv[s]  = wr_en && (wr_addr == ADDR_W'(RXV_A));
                we_io[s]   = wr_en && (wr_addr == ADDR_W'(IO_A));
            end
        end
    endgenerate

endmodule

// File: rtl/atr_bank_regs.sv
// Module: atr_bank_regs
// Holds one bank's mask, transmit pattern, receive pattern and software
// output register. Assumes at most one strobe is high per cycle.
module atr_bank_regs #(
    parameter int BANK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_mask,
    input  logic              we_txv,
    input  logic              we_rxv,
    input  logic              we_io,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] txv_q,
    output logic [BANK_W-1:0] rxv_q,
    output logic [BANK_W-1:0] io_q
);

    // Load the mask register on its strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (we_mask) mask_q <= wr_data;
    end

    // Load the transmit pattern on its strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      txv_q <= '0;
        else if (we_txv) txv_q <= wr_data;
    end

    // Load the receive pattern on its strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      rxv_q <= '0;
        else if (we_rxv) rxv_q <= wr_data;
    end

    // Load the software output register on its strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     io_q <= '0;
        else if (we_io) io_q <= wr_data;
    end

endmodule

// File: rtl/atr_mode_reg.sv
// Module: atr_mode_reg
// Captures the FIFO-holds-data flag once so all banks switch on one edge.
// Assumes txq_nonempty is already synchronous to clk.
module atr_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic txq_nonempty,
    output logic tx_mode_q
);

    // Single capture stage for the traffic flag.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_mode_q <= 1'b0;
        else        tx_mode_q <= txq_nonempty;
    end

endmodule

// File: rtl/atr_bit_merge.sv
// Module: atr_bit_merge
// Per-pin selection: masked pins take the pattern chosen by tx_mode,
// unmasked pins take the software output value. Purely combinational.
module atr_bit_merge #(
    parameter int BANK_W = 16
) (
    input  logic              tx_mode,
    input  logic [BANK_W-1:0] mask,
    input  logic [BANK_W-1:0] txv,
    input  logic [BANK_W-1:0] rxv,
    input  logic [BANK_W-1:0] io,
    output logic [BANK_W-1:0] pins
);

    genvar b;
    generate
        for (b = 0; b < BANK_W; b++) begin : g_bit
            // Pick the switched value, then choose it or the software bit.
            always_comb begin
                logic sw_bit;
                sw_bit  = tx_mode ? txv[b] : rxv[b];
                pins[b] = mask[b] ? sw_bit : io[b];
            end
        end
    endgenerate

endmodule

// File: rtl/atr_gpio_switcher.sv
// Module: atr_gpio_switcher (top)
// Four-bank pin driver with traffic-driven switching of masked pins.
// Assumes a single-cycle write port and a synchronous traffic flag.
module atr_gpio_switcher #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 16,
    parameter int ADDR_W    = 7,
    parameter int ATR_BASE  = 20,
    parameter int IO_BASE   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BANK_W-1:0]           wr_data,
    input  logic                        txq_nonempty,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out
);

    localparam int PIN_W = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0]             we_mask, we_txv, we_rxv, we_io;
    logic [NUM_BANKS-1:0][BANK_W-1:0] mask_q, txv_q, rxv_q, io_q, pins_b;
    logic                             tx_mode_q;

    atr_reg_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .ATR_BASE  (ATR_BASE),
        .IO_BASE   (IO_BASE)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .we_mask (we_mask),
        .we_txv  (we_txv),
        .we_rxv  (we_rxv),
        .we_io   (we_io)
    );

    atr_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .txq_nonempty (txq_nonempty),
        .tx_mode_q    (tx_mode_q)
    );

    genvar s;
    generate
        for (s = 0; s < NUM_BANKS; s++) begin : g_bank
            atr_bank_regs #(.BANK_W(BANK_W)) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_mask (we_mask[s]),
                .we_txv  (we_txv[s]),
                .we_rxv  (we_rxv[s]),
                .we_io   (we_io[s]),
                .wr_data (wr_data),
                .mask_q  (mask_q[s]),
                .txv_q   (txv_q[s]),
                .rxv_q   (rxv_q[s]),
                .io_q    (io_q[s])
            );

            atr_bit_merge #(.BANK_W(BANK_W)) u_merge (
                .tx_mode (tx_mode_q),
                .mask    (mask_q[s]),
                .txv     (txv_q[s]),
                .rxv     (rxv_q[s]),
                .io      (io_q[s]),
                .pins    (pins_b[s])
            );
        end
    endgenerate

    // Pack bank outputs; bank s lands in the s-th BANK_W slice (R11).
    always_comb pin_out = PIN_W'(pins_b);

endmodule

// File: rtl/atr_gpio_switcher_chk.sv
// Module: atr_gpio_switcher_chk
// Property checker bound to the top; observes ports and bank state.
module atr_gpio_switcher_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 16,
    parameter int ADDR_W    = 7,
    parameter int ATR_BASE  = 20,
    parameter int IO_BASE   = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [BANK_W-1:0]                wr_data,
    input logic                             txq_nonempty,
    input logic [NUM_BANKS*BANK_W-1:0]      pin_out,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] mask_q,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] txv_q,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] rxv_q,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] io_q,
    input logic                             tx_mode_q
);

    logic mapped;
    always_comb begin
        mapped = ((int'(wr_addr) >= ATR_BASE) && (int'(wr_addr) < ATR_BASE + 3 * NUM_BANKS))
              || ((int'(wr_addr) >= IO_BASE) && (int'(wr_addr) < IO_BASE + NUM_BANKS));
    end

    // R1: first cycle out of reset shows all-zero pins.
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0));

    // R7: the flag is captured with exactly one cycle of delay.
    a_r7_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (tx_mode_q == $past(txq_nonempty)));

    // R10: with no write strobe, no register moves.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$rose(rst_n)) |=> ($stable(mask_q) && $stable(txv_q) && $stable(rxv_q) && $stable(io_q)));

    // R8: unmapped writes change no register.
    a_r8_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(mask_q) && $stable(txv_q) && $stable(rxv_q) && $stable(io_q)));

    genvar s;
    generate
        for (s = 0; s < NUM_BANKS; s++) begin : g_chk
            // R2: a mask write at this slot's address lands in its mask.
            a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(ATR_BASE + 3 * s)) |=> (mask_q[s] == $past(wr_data)));

            // R2: a software-output write lands in this slot's register.
            a_r2_io_write: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(IO_BASE + s)) |=> (io_q[s] == $past(wr_data)));

            // R4: a bank with no mask bits shows its software output.
            a_r4_unmasked_io: assert property (@(posedge clk) disable iff (!rst_n)
                (mask_q[s] == '0) |-> (pin_out[s*BANK_W +: BANK_W] == io_q[s]));

            // R5: a fully masked bank in transmit mode shows its transmit pattern.
            a_r5_full_tx: assert property (@(posedge clk) disable iff (!rst_n)
                (&mask_q[s] && tx_mode_q) |-> (pin_out[s*BANK_W +: BANK_W] == txv_q[s]));

            // R6: a fully masked bank in receive mode shows its receive pattern.
            a_r6_full_rx: assert property (@(posedge clk) disable iff (!rst_n)
                (&mask_q[s] && !tx_mode_q) |-> (pin_out[s*BANK_W +: BANK_W] == rxv_q[s]));
        end
    endgenerate

endmodule

bind atr_gpio_switcher atr_gpio_switcher_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .ATR_BASE  (ATR_BASE),
    .IO_BASE   (IO_BASE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .txq_nonempty (txq_nonempty),
    .pin_out      (pin_out),
    .mask_q       (mask_q),
    .txv_q        (txv_q),
    .rxv_q        (rxv_q),
    .io_q         (io_q),
    .tx_mode_q    (tx_mode_q)
);

// File: tb/atr_gpio_switcher_tb_top.sv
// Bench for atr_gpio_switcher: a vector table, then directed tests.
module atr_gpio_switcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        txq_nonempty = 1'b0;
    logic [63:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    atr_gpio_switcher dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .txq_nonempty (txq_nonempty),
        .pin_out      (pin_out)
    );

    typedef struct packed {
        logic [1:0]  bank;
        logic [15:0] m;
        logic [15:0] t;
        logic [15:0] r;
        logic [15:0] i;
        logic        st;
        logic [15:0] exp;
    } vec_t;

    // Expected slices worked out by hand from R4, R5 and R6.
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h1234, 1'b1, 16'hA5A5},
        '{2'd0, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h1234, 1'b0, 16'h5A5A},
        '{2'd1, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hBEEF, 1'b1, 16'hBEEF},
        '{2'd2, 16'hFF00, 16'h12AB, 16'h34CD, 16'h5678, 1'b1, 16'h1278},
        '{2'd2, 16'hFF00, 16'h12AB, 16'h34CD, 16'h5678, 1'b0, 16'h3478},
        '{2'd3, 16'h0F0F, 16'hFFFF, 16'h0000, 16'hF0F0, 1'b0, 16'hF0F0},
        '{2'd3, 16'h0F0F, 16'hFFFF, 16'h0000, 16'hF0F0, 1'b1, 16'hFFFF},
        '{2'd1, 16'hAAAA, 16'hFFFF, 16'h0000, 16'h5555, 1'b0, 16'h5555}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write, driven at a falling edge, strobe dropped at the next.
    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", pin_out, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pin_out, 64'h0);

        // Table walk: R2 map, R4/R5/R6 merge, R11 slice position.
        for (int v = 0; v < NV; v++) begin
            wr(7'(20 + 3 * VECS[v].bank), VECS[v].m);
            wr(7'(21 + 3 * VECS[v].bank), VECS[v].t);
            wr(7'(22 + 3 * VECS[v].bank), VECS[v].r);
            wr(7'(8 + VECS[v].bank), VECS[v].i);
            txq_nonempty = VECS[v].st;
            @(negedge clk);
            check($sformatf("R2 R4 R5 R6 R11 vector %0d", v),
                  64'(pin_out[VECS[v].bank*16 +: 16]), 64'(VECS[v].exp));
        end

        // R9: every bank keeps its own last-written pattern.
        check("R9 banks independent", pin_out, 64'hF0F0_3478_5555_5A5A);

        // R8: unmapped addresses.
        wr(7'd0,  16'hFFFF);
        wr(7'd12, 16'hFFFF);
        wr(7'd19, 16'hFFFF);
        wr(7'd40, 16'hFFFF);
        @(negedge clk);
        check("R8 unmapped writes", pin_out, 64'hF0F0_3478_5555_5A5A);

        // R10: data on the bus without the strobe.
        @(negedge clk);
        wr_addr = 7'd8; wr_data = 16'h0000;
        @(negedge clk);
        wr_addr = 7'd20;
        @(negedge clk);
        check("R10 no strobe", pin_out, 64'hF0F0_3478_5555_5A5A);

        // R3: write takes effect after its edge, not before.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd9; wr_data = 16'h0F0F;  // bank1 software reg, mask AAAA
        #1;
        check("R3 before edge", pin_out, 64'hF0F0_3478_5555_5A5A);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 after edge", pin_out, 64'hF0F0_3478_0505_5A5A);

        // R7: flag change shows one edge later on all banks together.
        @(negedge clk);
        txq_nonempty = 1'b1;
        #1;
        check("R7 before capture", pin_out, 64'hF0F0_3478_0505_5A5A);
        @(negedge clk);
        check("R7 after capture", pin_out, 64'hFFFF_1278_AFAF_A5A5);

        // R4: unmasked bank 1 pins follow the software register in both modes.
        wr(7'd20 + 7'd3, 16'h0000);
        check("R4 mask cleared tx", pin_out[31:16], 16'h0F0F);
        txq_nonempty = 1'b0;
        @(negedge clk);
        check("R4 mask cleared rx", pin_out[31:16], 16'h0F0F);

        // R1: mid-run reset clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", pin_out, 64'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule